// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single internal access requests into external bus cycles on a multiplexed address/data bus. Each cycle starts with an address phase. The address latch strobe is high and the low address half is on the shared lines. A data phase follows, with the read or write strobe held low for one clock plus a programmable number of wait clocks. The block then pulses a one-clock completion flag and returns the read data.

The top two address bits select one of four regions. Region 0 is the internal area and drives no chip select. Regions 1 to 3 are external. Each region has its own 2-bit wait count. An active-low ready input can stretch the last data clock of an external access, but only when that access has waits. The upper address lines can carry chip selects in place of address bits. A byte-mode input selects an 8-bit data path or a 16-bit one. A new request is issued only while the block is idle.

Top module: `mux_bus_ctrl`

## Requirements
- R1: The clock edge that accepts `req_i` starts a one-clock address phase. In it, `ale_o` is 1, `ad_o` carries address bits [15:0] and `ad_oe_o` = 2'b11. Logic that latches `ad_o` while `ale_o` is high holds the request address once the strobe falls.
- R2: Every request produces the address phase and the strobe pulse, including requests to region 0 (address bits [23:22] = 0, the internal area).
- R3: After the address phase, `rd_no` (read) or `wr_no` (write) is low for 1+W clocks. W is `wait_cfg_i[2r+1:2r]` and r = address bits [23:22]. The two strobes are never low together.
- R4: `done_o` is high for exactly one clock, the clock after the strobe returns high. Counting the accepting edge as edge 0, it rises on edge 2+W+S, where S is the number of accepted ready stretches.
- R5: `rdy_ni` is sampled on the falling clock edge. A low sample in the last data clock adds one data clock, provided the region is 1 to 3 and W>0. Each further low sample adds another clock.
- R6: `rdy_ni` has no effect when W=0 or when the region is 0.
- R7: A low `rdy_ni` sampled in a data clock that still has waits remaining (the clock before the last wait) is not accepted.
- R8: During a stretch, and throughout any data phase, `ad_o`, `ad_oe_o`, `addr_hi_o` and the strobes keep their values.
- R9: In a read data phase the data byte lanes are released. With `byte_mode_i`=0, `ad_oe_o` = 2'b00. With `byte_mode_i`=1, `ad_oe_o` = 2'b10 and `ad_o[15:8]` keeps address bits [15:8].
- R10: With `byte_mode_i`=1, data uses only `ad_o[7:0]`/`ad_i[7:0]`, and `rdata_o` = {8'h00, `ad_i[7:0]`}. With `byte_mode_i`=0, a word access (`req_word_i`=1) uses all 16 lines. A byte access drives `{wdata[7:0], wdata[7:0]}` and returns the zero-extended low byte. Write data phases drive `ad_oe_o` = 2'b11.
- R11: With `cs_sel_i`=1, `addr_hi_o[4+r]` is the active-low select for region r (1..3). It is low only during the address and data phases of a cycle to region r. With `cs_sel_i`=0, `addr_hi_o` carries address bits [23:16].
- R12: In reset, `ale_o`=0, `rd_no`=`wr_no`=1, `ad_oe_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (only while idle) |
| req_addr_i | input | 24 | Access address |
| req_wdata_i | input | 16 | Write data |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data of the last read |
| byte_mode_i | input | 1 | 1 = 8-bit external data path |
| cs_sel_i | input | 1 | 1 = top address lines carry chip selects |
| wait_cfg_i | input | 8 | 2-bit wait count per region, region r at [2r+1:2r] |
| rdy_ni | input | 1 | Active-low ready (stretch) request |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ad_o | output | 16 | Multiplexed address/data out |
| ad_oe_o | output | 2 | Output enable per byte lane of `ad_o` |
| ad_i | input | 16 | Multiplexed data in |
| addr_hi_o | output | 8 | Upper address lines or chip selects |

## Verification
The properties assume that requests arrive only while the block is idle. They also assume that configuration, byte-mode and chip-select inputs do not change while a cycle is in flight. The bench meets both conditions: a task drives each access, waits for the completion pulse and a return to idle, and only then moves on. It changes `rdy_ni` only shortly after a rising edge, so every falling-edge sample sees a settled level. A modelled device latches `ad_o` while `ale_o` is high and answers reads from that latched value, so read data also confirms the address timing.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } bus_state_e;
endpackage

// File: rtl/mbc_region_dec.sv
module mbc_region_dec #(
  parameter int AW     = 24,
  parameter int NUM_CS = 3,
  parameter int WW     = 2
) (
  input  logic [AW-1:0]            addr_i,
  input  logic [(NUM_CS+1)*WW-1:0] wait_cfg_i,
  input  logic                     active_i,
  output logic [WW-1:0]            waits_o,
  output logic                     ext_o,
  output logic [NUM_CS-1:0]        cs_no
);
  localparam int RW = $clog2(NUM_CS + 1);

  logic [RW-1:0] region;
  assign region  = addr_i[AW-1 -: RW];
  assign waits_o = wait_cfg_i[int'(region)*WW +: WW];
  assign ext_o   = region != '0;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(active_i && (region == RW'(g + 1)));
  end
endmodule

// File: rtl/mbc_rdy_sample.sv
module mbc_rdy_sample (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_ni,
  output logic stretch_o
);
  logic smp_q;

  // ready is observed on the falling edge of the bus clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= 1'b1;
    else         smp_q <= rdy_ni;
  end

  assign stretch_o = ~smp_q;
endmodule

// File: rtl/mbc_ad_path.sv
module mbc_ad_path import mbc_pkg::*; #(
  parameter int DW = 16
) (
  input  bus_state_e    state_i,
  input  logic [DW-1:0] addr_lo_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          word_i,
  input  logic          byte_mode_i,
  output logic [DW-1:0] ad_o,
  output logic [1:0]    oe_o
);
  localparam int HW = DW / 2;

  always_comb begin
    ad_o = addr_lo_i;
    oe_o = 2'b00;
    unique case (state_i)
      ST_ADDR: oe_o = 2'b11;
      ST_DATA: begin
        if (byte_mode_i) begin
          // upper lane keeps non-multiplexed address bits
          ad_o = {addr_lo_i[DW-1:HW], wdata_i[HW-1:0]};
          oe_o = we_i ? 2'b11 : 2'b10;
        end else begin
          ad_o = word_i ? wdata_i : {wdata_i[HW-1:0], wdata_i[HW-1:0]};
          oe_o = we_i ? 2'b11 : 2'b00;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl import mbc_pkg::*; #(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int NUM_CS = 3,
  parameter int WW     = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [AW-1:0]            req_addr_i,
  input  logic [DW-1:0]            req_wdata_i,
  input  logic                     req_we_i,
  input  logic                     req_word_i,
  output logic                     done_o,
  output logic [DW-1:0]            rdata_o,
  input  logic                     byte_mode_i,
  input  logic                     cs_sel_i,
  input  logic [(NUM_CS+1)*WW-1:0] wait_cfg_i,
  input  logic                     rdy_ni,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DW-1:0]            ad_o,
  output logic [1:0]               ad_oe_o,
  input  logic [DW-1:0]            ad_i,
  output logic [AW-DW-1:0]         addr_hi_o
);
  localparam int HI_W = AW - DW;
  localparam int HW   = DW / 2;

  bus_state_e     st_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic           we_q, word_q, byte_q, cssel_q, done_q, has_wait_q;
  logic [WW-1:0]  wcnt_q;
  logic [WW-1:0]  waits;
  logic           ext;
  logic [NUM_CS-1:0] cs_n;
  logic           stretch_req;
  logic           active;

  assign active = st_q != ST_IDLE;

  mbc_region_dec #(.AW(AW), .NUM_CS(NUM_CS), .WW(WW)) i_dec (
    .addr_i     (addr_q),
    .wait_cfg_i (wait_cfg_i),
    .active_i   (active),
    .waits_o    (waits),
    .ext_o      (ext),
    .cs_no      (cs_n)
  );

  mbc_rdy_sample i_rdy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rdy_ni    (rdy_ni),
    .stretch_o (stretch_req)
  );

  mbc_ad_path #(.DW(DW)) i_ad (
    .state_i     (st_q),
    .addr_lo_i   (addr_q[DW-1:0]),
    .wdata_i     (wdata_q),
    .we_i        (we_q),
    .word_i      (word_q),
    .byte_mode_i (byte_q),
    .ad_o        (ad_o),
    .oe_o        (ad_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      we_q       <= 1'b0;
      word_q     <= 1'b0;
      byte_q     <= 1'b0;
      cssel_q    <= 1'b0;
      done_q     <= 1'b0;
      has_wait_q <= 1'b0;
      wcnt_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          we_q    <= req_we_i;
          word_q  <= req_word_i;
          byte_q  <= byte_mode_i;
          cssel_q <= cs_sel_i;
          st_q    <= ST_ADDR;
        end
        ST_ADDR: begin
          wcnt_q     <= waits;
          has_wait_q <= waits != '0;
          st_q       <= ST_DATA;
        end
        ST_DATA: begin
          if (wcnt_q != '0) begin
            wcnt_q <= wcnt_q - WW'(1);
          end else if (!(has_wait_q && ext && stretch_req)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            if (!we_q)
              rdata_q <= (byte_q || !word_q) ? {{HW{1'b0}}, ad_i[HW-1:0]} : ad_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ale_o     = st_q == ST_ADDR;
  assign rd_no     = !(st_q == ST_DATA && !we_q);
  assign wr_no     = !(st_q == ST_DATA && we_q);
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign addr_hi_o = cssel_q ? {cs_n, addr_q[AW-NUM_CS-1:DW]} : addr_q[AW-1:DW];

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk #(
  parameter int DW   = 16,
  parameter int HI_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ale_o,
  input logic            rd_no,
  input logic            wr_no,
  input logic            done_o,
  input logic [DW-1:0]   ad_o,
  input logic [1:0]      ad_oe_o,
  input logic [HI_W-1:0] addr_hi_o
);
  assert_ale_one_clock_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  assert_ale_then_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (!rd_no || !wr_no));

  assert_strobes_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_in_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_no && $past(!rd_no)) || (!wr_no && $past(!wr_no)))
      |-> ($stable(ad_o) && $stable(ad_oe_o) && $stable(addr_hi_o)));

  assert_read_releases_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o[0]);
endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk #(.DW(DW), .HI_W(HI_W)) i_mux_bus_ctrl_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ale_o     (ale_o),
  .rd_no     (rd_no),
  .wr_no     (wr_no),
  .done_o    (done_o),
  .ad_o      (ad_o),
  .ad_oe_o   (ad_oe_o),
  .addr_hi_o (addr_hi_o)
);

// File: tb/test_mux_bus_ctrl.sv
`timescale 1ns/1ps
module test_mux_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_we_i = 1'b0;
  logic        req_word_i = 1'b0;
  logic        done_o;
  logic [15:0] rdata_o;
  logic        byte_mode_i = 1'b0;
  logic        cs_sel_i = 1'b0;
  logic [7:0]  wait_cfg_i;
  logic        rdy_ni = 1'b1;
  logic        ale_o, rd_no, wr_no;
  logic [15:0] ad_o, ad_i;
  logic [1:0]  ad_oe_o;
  logic [7:0]  addr_hi_o;

  // waits: region0=2, region1=0, region2=1, region3=3
  assign wait_cfg_i = {2'd3, 2'd1, 2'd0, 2'd2};

  always #4 clk = ~clk;

  mux_bus_ctrl i_mux_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_we_i(req_we_i), .req_word_i(req_word_i),
    .done_o(done_o), .rdata_o(rdata_o), .byte_mode_i(byte_mode_i),
    .cs_sel_i(cs_sel_i), .wait_cfg_i(wait_cfg_i), .rdy_ni(rdy_ni),
    .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .ad_i(ad_i), .addr_hi_o(addr_hi_o)
  );

  // external device: captures the bus while the latch strobe is high
  logic [15:0] dev_lat = '0;
  always @(posedge clk) if (ale_o) dev_lat <= ad_o;
  assign ad_i = {dev_lat[15:8] ^ 8'h3C, dev_lat[7:0] ^ 8'h5A};

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          cyc;
    bit          rd;
    logic [15:0] data;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares completions against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R4 unexpected done", 32'(cyc), 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(cyc == e.cyc, {e.tag, " R4 done timing"}, 32'(cyc), 32'(e.cyc));
        if (e.rd) chk(rdata_o == e.data, {e.tag, " R10 read data"}, rdata_o, e.data);
      end
    end
  end

  task automatic run(input logic [23:0] a, input bit we, input bit word, input bit bm,
                     input bit cs, input logic [15:0] wd, input bit pre_rdy,
                     input int nstr, input string tag);
    int w, r, s, guard;
    logic [15:0] dev, exp_ad, snap_ad;
    logic [7:0] exp_hi, snap_hi;
    logic [1:0] snap_oe;
    exp_t e;
    r = int'(a[23:22]);
    w = int'(wait_cfg_i[2*r +: 2]);
    s = (w > 0 && r != 0) ? nstr : 0;
    dev = {a[15:8] ^ 8'h3C, a[7:0] ^ 8'h5A};
    e.cyc  = cyc + 1 + 2 + w + s;
    e.rd   = !we;
    e.data = (bm || !word) ? {8'h00, dev[7:0]} : dev;
    e.tag  = tag;
    sb_q.push_back(e);
    exp_hi = a[23:16];
    if (cs) begin
      exp_hi[7:5] = 3'b111;
      if (r != 0) exp_hi[4+r] = 1'b0;
    end
    req_addr_i = a; req_we_i = we; req_word_i = word; byte_mode_i = bm;
    cs_sel_i = cs; req_wdata_i = wd; req_i = 1'b1;
    @(posedge clk); #1;
    req_i = 1'b0;
    // address phase
    chk(ale_o == 1'b1, {tag, " R1/R2 ale high"}, ale_o, 1);
    chk(ad_o == a[15:0], {tag, " R1 address on ad"}, ad_o, a[15:0]);
    chk(rd_no && wr_no, {tag, " R3 strobes idle in address phase"}, {rd_no, wr_no}, 2'b11);
    chk(addr_hi_o == exp_hi, {tag, " R11 upper lines"}, addr_hi_o, exp_hi);
    @(posedge clk); #1;
    // data phase
    chk(ale_o == 1'b0, {tag, " R1 ale low in data"}, ale_o, 0);
    chk(we ? (!wr_no && rd_no) : (!rd_no && wr_no), {tag, " R3 strobe"}, {rd_no, wr_no}, we ? 2'b10 : 2'b01);
    chk(addr_hi_o == exp_hi, {tag, " R11 upper lines data"}, addr_hi_o, exp_hi);
    if (we) begin
      exp_ad = bm ? {a[15:8], wd[7:0]} : (word ? wd : {wd[7:0], wd[7:0]});
      chk(ad_o == exp_ad, {tag, " R10 write data"}, ad_o, exp_ad);
      chk(ad_oe_o == 2'b11, {tag, " R10 write enable"}, ad_oe_o, 2'b11);
    end else if (bm) begin
      chk(ad_oe_o == 2'b10, {tag, " R9 byte read release"}, ad_oe_o, 2'b10);
      chk(ad_o[15:8] == a[15:8], {tag, " R9 upper address kept"}, ad_o[15:8], a[15:8]);
    end else begin
      chk(ad_oe_o == 2'b00, {tag, " R9 word read release"}, ad_oe_o, 2'b00);
    end
    snap_ad = ad_o; snap_hi = addr_hi_o; snap_oe = ad_oe_o;
    rdy_ni = pre_rdy ? 1'b0 : 1'b1;
    repeat (w) @(posedge clk);
    #1;
    rdy_ni = (nstr > 0) ? 1'b0 : 1'b1;
    for (int k = 0; k < nstr; k++) begin
      @(posedge clk); #1;
      if (k == nstr - 1) rdy_ni = 1'b1;
      if (done_o) break;
      if (k < s) begin
        chk(we ? !wr_no : !rd_no, {tag, " R5 stretched strobe"}, {rd_no, wr_no}, 0);
        chk(ad_o == snap_ad && addr_hi_o == snap_hi && ad_oe_o == snap_oe,
            {tag, " R8 hold"}, {ad_o, addr_hi_o, 6'd0, ad_oe_o}, {snap_ad, snap_hi, 6'd0, snap_oe});
      end
    end
    rdy_ni = 1'b1;
    guard = 0;
    while (!done_o && guard < 20) begin
      @(posedge clk); #1;
      guard++;
    end
    @(posedge clk); #1;
    chk(!ale_o && rd_no && wr_no && ad_oe_o == 2'b00, {tag, " R3 idle after"},
        {ale_o, rd_no, wr_no, ad_oe_o}, 5'b01100);
    if (cs) chk(addr_hi_o[7:5] == 3'b111, {tag, " R11 selects released"}, addr_hi_o[7:5], 3'b111);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!ale_o && rd_no && wr_no && ad_oe_o == 2'b00 && !done_o, "R12 reset state",
        {ale_o, rd_no, wr_no, ad_oe_o, done_o}, 6'b011000);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    run(24'hC0_1234, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 0, "R3 word read r3");
    run(24'h40_ABCD, 1'b1, 1'b1, 1'b0, 1'b1, 16'hBEEF, 1'b0, 2, "R6 zero-wait ready ignored");
    run(24'h00_5566, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 2, "R2 R6 internal area");
    run(24'h80_0F0F, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 2, "R5 R8 stretch two");
    run(24'h80_7001, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 0, "R7 early ready ignored");
    run(24'hC0_3344, 1'b1, 1'b1, 1'b1, 1'b1, 16'hA1B2, 1'b0, 1, "R10 byte-mode write");
    run(24'h40_9988, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 0, "R10 byte-mode read");
    run(24'h80_2468, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 0, "R10 byte-size read");
    run(24'h40_1357, 1'b1, 1'b0, 1'b0, 1'b0, 16'h00C3, 1'b0, 0, "R10 byte-size write");
    run(24'hC0_FFEE, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 3, "R5 R8 stretch three");
    repeat (3) @(posedge clk);
    #1;
    chk(sb_q.size() == 0, "R4 all completions seen", sb_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule